// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Counter Chain

This block keeps the time of day and the calendar date as packed BCD bytes. It advances once per pulse on a one-second enable input that an upstream prescaler supplies. Seconds, minutes and hours count in 24-hour form. A day-of-week counter and a date counter both step at midnight. The date counter's upper limit follows the current month and a leap-year rule. The month and year counters follow, and a century flag can toggle when the year wraps.

A host bus interface sees eight byte-wide registers. It writes one register per cycle through a write port and reads any register through a combinational read port. A stop bit held in the seconds register freezes the whole chain. An enable bit held in the hours register decides whether the century flag follows year roll-overs. Every carry ripples within the same clock cycle as its tick, so all affected fields change on one edge.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers read, by address 0 to 7: 00, 00, 00, 01, 01, 01, 00, 00 (hex). The stop, century-enable and century bits are clear.
- R2: Each cycle with `tick_i` high and the stop bit clear advances seconds (address 0, bits 6:0) by one in BCD. 59 wraps to 00 and carries into minutes.
- R3: Minutes (address 1, bits 6:0) count 00 to 59 and carry into hours. Hours (address 2, bits 5:0) count 00 to 23. Past 23 they wrap to 00 and carry into the day counters.
- R4: Day-of-week (address 3, bits 2:0) counts 1 to 7 and wraps to 1. It steps on the same edge as the date.
- R5: Date (address 4, bits 5:0) counts from 01. Months 04, 06, 09 and 11 wrap after 30. Months 01, 03, 05, 07, 08, 10 and 12 wrap after 31. The wrap sets date to 01 and advances month (address 5, bits 4:0).
- R6: In February the date wraps after 29 when the year value is divisible by four (00 counts as divisible). In every other year it wraps after 28.
- R7: Month counts 01 to 12. Past 12 it wraps to 01 and advances the year (address 6, BCD 00 to 99). Year 99 wraps to 00.
- R8: Address 2 bit 7 is century enable and bit 6 is the century flag. When the year wraps from 99 to 00 with enable set, the flag toggles. With enable clear it holds.
- R9: Address 0 bit 7 is the stop bit. While it is set, ticks change no field. Once it is cleared, counting resumes from the held values.
- R10: A write (`wr_en_i`, `wr_addr_i`, `wr_data_i`) stores the byte in the addressed register on the next edge. It replaces any increment that register would have received in that cycle. Registers not written in that cycle still advance from the tick.
- R11: Bits that no field uses read as 0, whatever was written to them. Address 7 always reads 00, and writes to it change nothing.
- R12: A single tick at 23:59:59 on 31 December, year 99, produces 00:00:00, date 01, month 01 and year 00 on one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second count enable, one cycle per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write register address |
| wr_data_i | input | 8 | Host write byte |
| rd_addr_i | input | 3 | Host read register address |
| rd_data_o | output | 8 | Read byte of the addressed register, combinational |

## Verification
The assertions assume the host writes only valid BCD within each field's range. For example, the hour-range property relies on the hours field never being loaded above 23. The properties that depend on the tick chain only apply in cycles without a host write. The stimulus writes only legal time and date values, including boundary dates such as 28 or 29 February, 30 April and 31 December, and keeps the date valid for its month. The stimulus also covers writes that coincide with ticks, writes to unused bits and to address 7, stop and resume, and ticks both back-to-back and spaced by idle cycles.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int NUM_FIELDS = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_WDAY  = 3'd3,
    REG_DATE  = 3'd4,
    REG_MONTH = 3'd5,
    REG_YEAR  = 3'd6,
    REG_SPARE = 3'd7
  } reg_addr_e;

  // field storage masks, indexed by register address
  localparam logic [DATA_W-1:0] FIELD_MASK [NUM_FIELDS] =
    '{8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
  localparam logic [DATA_W-1:0] FIELD_RST [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  localparam logic [DATA_W-1:0] FIELD_MIN [NUM_FIELDS] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
  // date limit is dynamic; entry 4 is replaced at run time
  localparam logic [DATA_W-1:0] FIELD_MAX [NUM_FIELDS] =
    '{8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};
endpackage

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
module bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] max_i,
  input  logic         inc_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  logic at_top;
  assign at_top = (cur_i >= max_i);
  assign wrap_o = inc_i && at_top;

  always_comb begin
    if (!inc_i)                nxt_o = cur_i;
    else if (at_top)           nxt_o = min_i;
    else if (cur_i[3:0] >= 4'd9) nxt_o = {cur_i[W-1:4] + 1'b1, 4'h0};
    else                       nxt_o = cur_i + 1'b1;
  end
endmodule

// File: rtl/month_len.sv
`timescale 1ns/1ps
module month_len #(
  parameter int W = 8
) (
  input  logic [W-1:0] month_i,
  input  logic [W-1:0] year_i,
  output logic [W-1:0] last_day_o
);
  logic [W-1:0] year_bin;
  logic         leap;

  // tens*10 + units
  assign year_bin = ({4'h0, year_i[7:4]} << 3) + ({4'h0, year_i[7:4]} << 1) + {4'h0, year_i[3:0]};
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    unique case (month_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] field_q  [NUM_FIELDS];
  logic [DATA_W-1:0] field_nx [NUM_FIELDS];
  logic [DATA_W-1:0] lim_max  [NUM_FIELDS];
  logic              inc      [NUM_FIELDS];
  logic              wrap     [NUM_FIELDS];
  logic              stop_q, cen_en_q, cen_q;
  logic [DATA_W-1:0] last_day;

  month_len #(.W(DATA_W)) u_month_len (
    .month_i   (field_q[REG_MONTH]),
    .year_i    (field_q[REG_YEAR]),
    .last_day_o(last_day)
  );

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) lim_max[i] = FIELD_MAX[i];
    lim_max[REG_DATE] = last_day;
  end

  // carry chain; weekday and date both hang off the hour wrap
  always_comb begin
    inc[REG_SEC]   = tick_i && !stop_q;
    inc[REG_MIN]   = wrap[REG_SEC];
    inc[REG_HOUR]  = wrap[REG_MIN];
    inc[REG_WDAY]  = wrap[REG_HOUR];
    inc[REG_DATE]  = wrap[REG_HOUR];
    inc[REG_MONTH] = wrap[REG_DATE];
    inc[REG_YEAR]  = wrap[REG_MONTH];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    bcd_step #(.W(DATA_W)) u_step (
      .cur_i (field_q[g]),
      .min_i (FIELD_MIN[g]),
      .max_i (lim_max[g]),
      .inc_i (inc[g]),
      .nxt_o (field_nx[g]),
      .wrap_o(wrap[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_FIELDS; i++) field_q[i] <= FIELD_RST[i];
      stop_q   <= 1'b0;
      cen_en_q <= 1'b0;
      cen_q    <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++) begin
        if (wr_en_i && wr_addr_i == ADDR_W'(i)) field_q[i] <= wr_data_i & FIELD_MASK[i];
        else                                   field_q[i] <= field_nx[i];
      end
      if (wr_en_i && wr_addr_i == REG_SEC) stop_q <= wr_data_i[7];
      if (wr_en_i && wr_addr_i == REG_HOUR) begin
        cen_en_q <= wr_data_i[7];
        cen_q    <= wr_data_i[6];
      end else if (wrap[REG_YEAR] && cen_en_q) begin
        cen_q <= ~cen_q;
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      REG_SEC:   rd_data_o = field_q[REG_SEC] | {stop_q, 7'h00};
      REG_MIN:   rd_data_o = field_q[REG_MIN];
      REG_HOUR:  rd_data_o = field_q[REG_HOUR] | {cen_en_q, cen_q, 6'h00};
      REG_WDAY:  rd_data_o = field_q[REG_WDAY];
      REG_DATE:  rd_data_o = field_q[REG_DATE];
      REG_MONTH: rd_data_o = field_q[REG_MONTH];
      REG_YEAR:  rd_data_o = field_q[REG_YEAR];
      default:   rd_data_o = '0;
    endcase
  end

  // ---------------- assertions ----------------
  logic [DATA_W*NUM_FIELDS-1:0] time_vec;
  always_comb
    for (int i = 0; i < NUM_FIELDS; i++) time_vec[i*DATA_W +: DATA_W] = field_q[i];

  // R9
  stop_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_q && !wr_en_i |=> $stable(time_vec));

  // R2
  sec_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !stop_q && !wr_en_i |=> field_q[REG_SEC] != $past(field_q[REG_SEC]));

  // R3 (assumes host writes legal hours)
  hour_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_q[REG_HOUR] <= 8'h23);

  // R4
  wday_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap[REG_WDAY] && !wr_en_i |=> field_q[REG_WDAY] == 8'h01);

  // R8
  cen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && !cen_en_q |=> $stable(cen_q));

  // R8
  cen_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cen_q) || field_q[REG_YEAR] == 8'h00);

  // R10
  wr_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == REG_MIN |=> field_q[REG_MIN] == ($past(wr_data_i) & 8'h7F));
endmodule

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  // reference model state (plain integers)
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
  bit m_stop, m_cen_en, m_cen;

  always #2 clk_i = ~clk_i;

  rtc_calendar u_dut (
    .clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o
  );

  function automatic logic [7:0] i2b(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    case (a)
      0: return {m_stop, 7'(i2b(m_sec))};
      1: return i2b(m_min);
      2: return {m_cen_en, m_cen, 6'(i2b(m_hr))};
      3: return i2b(m_dow);
      4: return i2b(m_date);
      5: return i2b(m_mon);
      6: return i2b(m_yr);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2"; 1: return "R3"; 2: return "R8"; 3: return "R4";
      4: return "R5"; 5: return "R7"; 6: return "R7"; default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
    m_stop = 0; m_cen_en = 0; m_cen = 0;
  endtask

  task automatic model_step(bit tk, bit we, int wa, logic [7:0] wd);
    int ns = m_sec, nm = m_min, nh = m_hr, nd = m_dow, ndt = m_date, nmo = m_mon, ny = m_yr;
    bit nc = m_cen;
    if (tk && !m_stop) begin
      ns = m_sec + 1;
      if (ns == 60) begin
        ns = 0; nm = m_min + 1;
        if (nm == 60) begin
          nm = 0; nh = m_hr + 1;
          if (nh == 24) begin
            nh = 0;
            nd = (m_dow == 7) ? 1 : m_dow + 1;
            ndt = m_date + 1;
            if (ndt > dim(m_mon, m_yr)) begin
              ndt = 1; nmo = m_mon + 1;
              if (nmo == 13) begin
                nmo = 1; ny = m_yr + 1;
                if (ny == 100) begin
                  ny = 0;
                  if (m_cen_en) nc = !m_cen;
                end
              end
            end
          end
        end
      end
    end
    if (we) begin
      case (wa)
        0: begin m_stop = wd[7]; ns = b2i({1'b0, wd[6:0]}); end
        1: nm = b2i({1'b0, wd[6:0]});
        2: begin m_cen_en = wd[7]; nc = wd[6]; nh = b2i({2'b0, wd[5:0]}); end
        3: nd = int'(wd[2:0]);
        4: ndt = b2i({2'b0, wd[5:0]});
        5: nmo = b2i({3'b0, wd[4:0]});
        6: ny = b2i(wd);
        default: ;
      endcase
    end
    m_sec = ns; m_min = nm; m_hr = nh; m_dow = nd; m_date = ndt; m_mon = nmo; m_yr = ny;
    m_cen = nc;
  endtask

  task automatic check(int a, logic [7:0] exp, string tag);
    rd_addr_i = 3'(a);
    #0.1;
    n_chk++;
    if (rd_data_o !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual %h expected %h at %0t", tag, a, rd_data_o, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int a = 0; a < 8; a++) check(a, exp_reg(a), tag_of(a));
  endtask

  // one clock: inputs set after the falling edge, model updates at the rising edge
  task automatic cyc(bit tk, bit we, int wa, logic [7:0] wd);
    tick_i = tk; wr_en_i = we; wr_addr_i = 3'(wa); wr_data_i = wd;
    @(posedge clk_i);
    model_step(tk, we, wa, wd);
    @(negedge clk_i);
    tick_i = 0; wr_en_i = 0;
    compare_all();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00);
  endtask

  task automatic wr(int a, logic [7:0] d);
    cyc(0, 1, a, d);
  endtask

  task automatic set_all(logic [7:0] s, logic [7:0] mi, logic [7:0] h, logic [7:0] dw,
                         logic [7:0] dt, logic [7:0] mo, logic [7:0] y);
    wr(6, y); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, h); wr(1, mi); wr(0, s);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(0, 8'h00, "R1"); check(1, 8'h00, "R1"); check(2, 8'h00, "R1"); check(3, 8'h01, "R1");
    check(4, 8'h01, "R1"); check(5, 8'h01, "R1"); check(6, 8'h00, "R1"); check(7, 8'h00, "R1");

    // R2 / R3 back-to-back ticks
    ticks(130);
    check(0, 8'h10, "R2"); check(1, 8'h02, "R3");

    // R2 spaced ticks
    for (int i = 0; i < 40; i++) begin
      cyc(1, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
      cyc(0, 0, 0, 8'h00);
    end
    check(0, 8'h50, "R2");

    // R3 R4 R5 R6 non-leap February, weekday 7 wrap
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h03);
    ticks(1);
    check(2, 8'h00, "R3"); check(3, 8'h01, "R4"); check(4, 8'h01, "R6"); check(5, 8'h03, "R6");

    // R6 leap year 04
    set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h04);
    ticks(1);
    check(4, 8'h29, "R6"); check(5, 8'h02, "R6"); check(3, 8'h03, "R4");
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    check(4, 8'h01, "R6"); check(5, 8'h03, "R6");

    // R6 year 00 is leap
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h00);
    ticks(1);
    check(4, 8'h29, "R6");

    // R5 30-day and 31-day months
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h21);
    ticks(1);
    check(4, 8'h01, "R5"); check(5, 8'h05, "R5");
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h01, 8'h21);
    ticks(1);
    check(4, 8'h31, "R5"); check(5, 8'h01, "R5");
    wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    ticks(1);
    check(4, 8'h01, "R5"); check(5, 8'h02, "R5");

    // R7 R8 R12 full roll-over, century enabled
    set_all(8'h59, 8'h59, 8'hA3, 8'h06, 8'h31, 8'h12, 8'h99);
    ticks(1);
    check(0, 8'h00, "R12"); check(1, 8'h00, "R12"); check(2, 8'hC0, "R8");
    check(4, 8'h01, "R12"); check(5, 8'h01, "R7"); check(6, 8'h00, "R7");
    // R8 toggle back from set
    set_all(8'h59, 8'h59, 8'hE3, 8'h06, 8'h31, 8'h12, 8'h99);
    ticks(1);
    check(2, 8'h80, "R8");
    // R8 century disabled holds
    set_all(8'h59, 8'h59, 8'h63, 8'h06, 8'h31, 8'h12, 8'h99);
    ticks(1);
    check(2, 8'h40, "R8"); check(6, 8'h00, "R7");

    // R9 stop and resume
    wr(0, 8'h85);
    ticks(10);
    check(0, 8'h85, "R9"); check(1, 8'h00, "R9");
    wr(0, 8'h05);
    ticks(3);
    check(0, 8'h08, "R9");

    // R10 write coinciding with tick
    cyc(1, 1, 0, 8'h30);
    check(0, 8'h30, "R10");
    wr(0, 8'h59);
    cyc(1, 1, 1, 8'h10);
    check(0, 8'h00, "R10"); check(1, 8'h10, "R10");

    // R11 unused bits and spare address
    wr(7, 8'hFF);
    check(7, 8'h00, "R11");
    wr(1, 8'hA5);
    check(1, 8'h25, "R11");
    wr(3, 8'hFF);
    check(3, 8'h07, "R11");

    // long run across days
    set_all(8'h00, 8'h50, 8'h23, 8'h03, 8'h28, 8'h02, 8'h08);
    ticks(5000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule